// File: doc/BRIEF.md
# Wormhole XY Mesh Router

This block is one node of a two-dimensional grid network. It has five ports: one toward the local tile and one toward each of the four neighbouring nodes. Every port carries flits under valid/ready flow control. Each input port has a small flit queue. The head of a packet is the header flit, which holds the destination column, the destination row and the number of payload flits that follow it. The input port reads the header and picks an output port with dimension-ordered routing: first along the row until the column matches, then along the column.

Each output port is a small state machine, either FREE or HELD. A FREE output gives itself to one of the inputs that request it, chosen round-robin. It stays HELD for that input until the input has sent the number of payload flits written in the header. The header leaves as soon as the output is won, and the payload follows through the same output as it arrives. The whole packet is never stored first. When the next node stalls, the packet keeps every output it has already won.

Each input port is a state machine with three states. IDLE waits for a header at the queue head. Leaving IDLE latches the route and enters ROUTE. ROUTE requests the chosen output and sends the header once the output is granted. After the header it returns to IDLE if the length is zero, and otherwise enters BODY with the count loaded. BODY sends payload flits and counts them down, and returns to IDLE after the last one. The output machine moves from FREE to HELD on a grant, and from HELD back to FREE when its owner sends its last flit.

Top module: `xy_mesh_router`

## Requirements
- R1: Ports are numbered 0 local, 1 north (row increases), 2 east (column increases), 3 south and 4 west. Port k occupies bits [k*FLIT_W +: FLIT_W] of each flit bus. A header whose destination column is above, or below, the node's `pos_x` leaves east, or west. If the column matches, a destination row above, or below, `pos_y` leaves north, or south. If both match, the header leaves local.
- R2: In a header flit, bits [3:0] give the payload length L, bits [6:4] give the destination row and bits [9:7] give the destination column. Exactly L payload flits follow the header.
- R3: The payload flits of a packet leave through the same output as their header, unchanged and in arrival order.
- R4: Once an output is granted, no flit from any other input appears on it until the owner's last counted payload flit has been accepted.
- R5: A packet with L = 0 releases its output once the header is accepted, and a waiting packet then gets that output.
- R6: Each output grants round-robin. After reset, input 0 has the highest priority. After a packet from input i completes, the search for the next owner starts at input i+1 and wraps around.
- R7: While `out_ready` is low, `out_valid` and `out_flit` on that port stay unchanged. The stalled packet keeps its output, so a competing packet waits.
- R8: An input port holds at most DEPTH flits (4 by default). `in_ready` is low while it holds DEPTH flits.
- R9: During and right after reset, every `out_valid` is low and every `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pos_x | input | COORD_W | Column of this node |
| pos_y | input | COORD_W | Row of this node |
| in_flit | input | 5*FLIT_W | Incoming flits, one slot per port |
| in_valid | input | 5 | Incoming flit valid, per port |
| in_ready | output | 5 | Input queue can accept, per port |
| out_flit | output | 5*FLIT_W | Outgoing flits, one slot per port |
| out_valid | output | 5 | Outgoing flit valid, per port |
| out_ready | input | 5 | Downstream accepts, per port |

## Verification
The properties assume well-formed traffic. Whenever an input queue is idle, its head flit must be a header, and each header must be followed by exactly its stated number of payload flits. The bench sends only whole packets built from its own header encoder, so that condition holds for all stimulus. The properties also assume that `pos_x` and `pos_y` stay fixed while packets are in flight. The bench ties them to column 2, row 2 for the whole run. The stall property takes nothing about `out_ready` for granted. The bench lowers it for long stretches while the input queue fills.

// File: rtl/xyr_pkg.sv
package xyr_pkg;
    localparam int NPORT = 5;
    localparam int PW    = 3;

    typedef enum logic [PW-1:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_EAST  = 3'd2,
        P_SOUTH = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    typedef enum logic [1:0] {IN_IDLE, IN_ROUTE, IN_BODY} in_st_e;
    typedef enum logic {OUT_FREE, OUT_HELD} out_st_e;
endpackage

// File: rtl/xyr_fifo.sv
module xyr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    // R3: the forwarding side never takes a flit that is not there
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/xyr_input.sv
module xyr_input
    import xyr_pkg::*;
#(
    parameter int FLIT_W  = 16,
    parameter int COORD_W = 3,
    parameter int LEN_W   = 4,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [FLIT_W-1:0]  in_flit,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               gnt,
    input  logic               dn_ready,
    output logic               req,
    output port_e              route,
    output logic [FLIT_W-1:0]  head_flit,
    output logic               head_valid,
    output logic               fire,
    output logic               last
);
    localparam int Y_LO = LEN_W;
    localparam int X_LO = LEN_W + COORD_W;

    in_st_e             st, st_nx;
    port_e              route_c;
    logic [LEN_W-1:0]   cnt;
    logic               full, empty, send;
    logic [LEN_W-1:0]   h_len;
    logic [COORD_W-1:0] h_x, h_y;

    xyr_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid && !full),
        .pop   (fire),
        .din   (in_flit),
        .dout  (head_flit),
        .full  (full),
        .empty (empty)
    );

    assign in_ready = !full;
    assign h_len    = head_flit[LEN_W-1:0];
    assign h_y      = head_flit[Y_LO +: COORD_W];
    assign h_x      = head_flit[X_LO +: COORD_W];

    always_comb begin
        if (h_x > pos_x)      route_c = P_EAST;
        else if (h_x < pos_x) route_c = P_WEST;
        else if (h_y > pos_y) route_c = P_NORTH;
        else if (h_y < pos_y) route_c = P_SOUTH;
        else                  route_c = P_LOCAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= IN_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route <= P_LOCAL;
            cnt   <= '0;
        end else begin
            if (st == IN_IDLE && !empty) route <= route_c;
            if (fire && st == IN_ROUTE)  cnt <= h_len;
            else if (fire)               cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            IN_IDLE:  if (!empty) st_nx = IN_ROUTE;
            IN_ROUTE: if (fire)   st_nx = (h_len == '0) ? IN_IDLE : IN_BODY;
            IN_BODY:  if (fire && cnt == LEN_W'(1)) st_nx = IN_IDLE;
            default:  st_nx = IN_IDLE;
        endcase
    end

    always_comb begin
        req        = (st == IN_ROUTE);
        send       = (st == IN_ROUTE || st == IN_BODY) && gnt;
        head_valid = send && !empty;
        fire       = head_valid && dn_ready;
        last       = (st == IN_ROUTE) ? (h_len == '0) : (cnt == LEN_W'(1));
    end

    // R4: a worm in its body always has payload left to send
    p_body_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IN_BODY) |-> (cnt != '0));
endmodule

// File: rtl/xyr_output.sv
module xyr_output
    import xyr_pkg::*;
#(
    parameter int FLIT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        req,
    input  logic [NPORT-1:0]        rel,
    input  logic [NPORT-1:0]        vld,
    input  logic [NPORT*FLIT_W-1:0] flit_bus,
    output logic [FLIT_W-1:0]       out_flit,
    output logic                    out_valid,
    output logic                    held,
    output logic [PW-1:0]           owner
);
    out_st_e       st, st_nx;
    logic [PW-1:0] ptr, win;
    logic          any;
    int            idx;

    always_comb begin
        win = '0;
        any = 1'b0;
        idx = 0;
        for (int k = 0; k < NPORT; k++) begin
            idx = int'(ptr) + k;
            if (idx >= NPORT) idx = idx - NPORT;
            if (!any && req[idx]) begin
                any = 1'b1;
                win = PW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= OUT_FREE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner <= '0;
            ptr   <= '0;
        end else begin
            if (st == OUT_FREE && any) owner <= win;
            if (st == OUT_HELD && rel[owner])
                ptr <= (owner == PW'(NPORT - 1)) ? '0 : owner + 1'b1;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            OUT_FREE: if (any)        st_nx = OUT_HELD;
            OUT_HELD: if (rel[owner]) st_nx = OUT_FREE;
            default:  st_nx = OUT_FREE;
        endcase
    end

    always_comb begin
        held      = (st == OUT_HELD);
        out_valid = held && vld[owner];
        out_flit  = flit_bus[owner*FLIT_W +: FLIT_W];
    end

    // R4: the owner cannot change before it releases
    p_owner_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !rel[owner]) |=> (held && $stable(owner)));
endmodule

// File: rtl/xy_mesh_router.sv
module xy_mesh_router
    import xyr_pkg::*;
#(
    parameter int FLIT_W  = 16,
    parameter int COORD_W = 3,
    parameter int LEN_W   = 4,
    parameter int DEPTH   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COORD_W-1:0]      pos_x,
    input  logic [COORD_W-1:0]      pos_y,
    input  logic [NPORT*FLIT_W-1:0] in_flit,
    input  logic [NPORT-1:0]        in_valid,
    output logic [NPORT-1:0]        in_ready,
    output logic [NPORT*FLIT_W-1:0] out_flit,
    output logic [NPORT-1:0]        out_valid,
    input  logic [NPORT-1:0]        out_ready
);
    logic [NPORT-1:0]        req_v, fire_v, last_v, rel_v, hv_v, gnt_v, dn_v, held_v;
    port_e                   route_a [NPORT];
    logic [PW-1:0]           owner_a [NPORT];
    logic [NPORT-1:0]        req_m   [NPORT];
    logic [NPORT*FLIT_W-1:0] head_bus;

    assign rel_v = fire_v & last_v;

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            gnt_v[i] = held_v[route_a[i]] && (owner_a[route_a[i]] == PW'(i));
            dn_v[i]  = out_ready[route_a[i]];
        end
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++)
                req_m[o][i] = req_v[i] && (PW'(route_a[i]) == PW'(o));
    end

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        xyr_input #(
            .FLIT_W(FLIT_W), .COORD_W(COORD_W), .LEN_W(LEN_W), .DEPTH(DEPTH)
        ) u_in (
            .clk        (clk),
            .rst_n      (rst_n),
            .pos_x      (pos_x),
            .pos_y      (pos_y),
            .in_flit    (in_flit[gi*FLIT_W +: FLIT_W]),
            .in_valid   (in_valid[gi]),
            .in_ready   (in_ready[gi]),
            .gnt        (gnt_v[gi]),
            .dn_ready   (dn_v[gi]),
            .req        (req_v[gi]),
            .route      (route_a[gi]),
            .head_flit  (head_bus[gi*FLIT_W +: FLIT_W]),
            .head_valid (hv_v[gi]),
            .fire       (fire_v[gi]),
            .last       (last_v[gi])
        );
    end

    for (genvar go = 0; go < NPORT; go++) begin : g_out
        xyr_output #(.FLIT_W(FLIT_W)) u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_m[go]),
            .rel       (rel_v),
            .vld       (hv_v),
            .flit_bus  (head_bus),
            .out_flit  (out_flit[go*FLIT_W +: FLIT_W]),
            .out_valid (out_valid[go]),
            .held      (held_v[go]),
            .owner     (owner_a[go])
        );

        // R7: a refused flit is offered again unchanged
        p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[go] && !out_ready[go]) |=>
            (out_valid[go] && $stable(out_flit[go*FLIT_W +: FLIT_W])));

        // R1: an output is only ever owned by an input routed to it
        p_owner_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
            held_v[go] |-> (PW'(route_a[owner_a[go]]) == PW'(go)));
    end
endmodule

// File: tb/sim_xy_mesh_router.sv
module sim_xy_mesh_router;
    localparam int NP = 5;
    localparam int FW = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic [2:0]      px = 3'd2;
    logic [2:0]      py = 3'd2;
    logic [NP*FW-1:0] in_bus, out_bus;
    logic [NP-1:0]   in_v, in_rdy, out_v, out_rdy;
    logic [FW-1:0]   in_f [NP];

    for (genvar k = 0; k < NP; k++) begin : g_bus
        assign in_bus[k*FW +: FW] = in_f[k];
    end

    xy_mesh_router u0 (
        .clk(clk), .rst_n(rst_n), .pos_x(px), .pos_y(py),
        .in_flit(in_bus), .in_valid(in_v), .in_ready(in_rdy),
        .out_flit(out_bus), .out_valid(out_v), .out_ready(out_rdy)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string tag_now = "R1";
    logic [FW-1:0] expq [NP][$];

    function automatic int ref_port(int dx, int dy);
        if (dx > 2) return 2;
        if (dx < 2) return 4;
        if (dy > 2) return 1;
        if (dy < 2) return 3;
        return 0;
    endfunction

    function automatic logic [FW-1:0] hdr(int dx, int dy, int len);
        return FW'((dx << 7) | (dy << 4) | len);
    endfunction

    function automatic logic [FW-1:0] pay(int tag, int j);
        return FW'((tag << 8) | j);
    endfunction

    function automatic void expect_pkt(int dx, int dy, int len, int tag);
        int o = ref_port(dx, dy);
        expq[o].push_back(hdr(dx, dy, len));
        for (int j = 0; j < len; j++) expq[o].push_back(pay(tag, j));
    endfunction

    task automatic check(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (out_v[p] && out_rdy[p]) begin
                    if (expq[p].size() == 0) begin
                        checks++;
                        fails++;
                        $display("FAIL %s: port %0d actual %0h expected none",
                                 tag_now, p, out_bus[p*FW +: FW]);
                    end else begin
                        check(tag_now, int'(out_bus[p*FW +: FW]), int'(expq[p].pop_front()));
                    end
                end
            end
        end
    end

    task automatic drive(int p, logic [FW-1:0] f);
        @(posedge clk); #1;
        in_v[p] = 1'b1;
        in_f[p] = f;
        while (!in_rdy[p]) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic send_pkt(int p, int dx, int dy, int len, int tag);
        drive(p, hdr(dx, dy, len));
        for (int j = 0; j < len; j++) drive(p, pay(tag, j));
        @(posedge clk); #1;
        in_v[p] = 1'b0;
    endtask

    task automatic drain(string r);
        for (int n = 0; n < 600; n++) begin
            int left = 0;
            for (int p = 0; p < NP; p++) left += expq[p].size();
            if (left == 0) break;
            @(posedge clk);
        end
        for (int p = 0; p < NP; p++) check(r, expq[p].size(), 0);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        in_v    = '0;
        out_rdy = '1;
        for (int k = 0; k < NP; k++) begin
            in_f[k] = '0;
            expq[k].delete();
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R9: reset state
        check("R9", int'(out_v), 0);
        check("R9", int'(in_rdy), 5'h1f);

        // R1 R2: one packet per direction, all at once
        tag_now = "R1";
        expect_pkt(4, 6, 2, 8'h10);
        expect_pkt(1, 1, 1, 8'h11);
        expect_pkt(2, 7, 3, 8'h12);
        expect_pkt(2, 1, 2, 8'h13);
        expect_pkt(2, 2, 1, 8'h14);
        fork
            send_pkt(0, 4, 6, 2, 8'h10);
            send_pkt(1, 1, 1, 1, 8'h11);
            send_pkt(2, 2, 7, 3, 8'h12);
            send_pkt(3, 2, 1, 2, 8'h13);
            send_pkt(4, 2, 2, 1, 8'h14);
        join
        drain("R2");

        // R3 R4: two long worms fight for south; one input changes direction
        do_reset();
        tag_now = "R4";
        expect_pkt(2, 0, 6, 8'h20);
        expect_pkt(2, 0, 6, 8'h24);
        expect_pkt(5, 2, 3, 8'h22);
        expect_pkt(0, 3, 2, 8'h23);
        fork
            send_pkt(0, 2, 0, 6, 8'h20);
            send_pkt(4, 2, 0, 6, 8'h24);
            begin
                send_pkt(2, 5, 2, 3, 8'h22);
                send_pkt(2, 0, 3, 2, 8'h23);
            end
        join
        drain("R3");

        // R5: zero-length header frees west for the next worm
        do_reset();
        tag_now = "R5";
        expect_pkt(0, 2, 0, 8'h31);
        expect_pkt(0, 2, 2, 8'h32);
        fork
            send_pkt(1, 0, 2, 0, 8'h31);
            send_pkt(2, 0, 2, 2, 8'h32);
        join
        drain("R5");

        // R6: round-robin on local, pointer moves past the last winner
        do_reset();
        tag_now = "R6";
        expect_pkt(2, 2, 1, 8'h40);
        expect_pkt(2, 2, 1, 8'h41);
        fork
            send_pkt(0, 2, 2, 1, 8'h40);
            send_pkt(1, 2, 2, 1, 8'h41);
        join
        drain("R6");
        expect_pkt(2, 2, 2, 8'h53);
        expect_pkt(2, 2, 2, 8'h50);
        expect_pkt(2, 2, 2, 8'h51);
        fork
            send_pkt(0, 2, 2, 2, 8'h50);
            send_pkt(1, 2, 2, 2, 8'h51);
            send_pkt(3, 2, 2, 2, 8'h53);
        join
        drain("R6");

        // R7 R8: stall east while the input queue fills
        do_reset();
        tag_now = "R7";
        out_rdy[2] = 1'b0;
        expect_pkt(6, 2, 5, 8'h60);
        expect_pkt(7, 4, 1, 8'h63);
        fork
            send_pkt(0, 6, 2, 5, 8'h60);
            send_pkt(3, 7, 4, 1, 8'h63);
        join_none
        repeat (12) @(posedge clk);
        @(negedge clk);
        check("R7", int'(out_v[2]), 1);
        check("R7", int'(out_bus[2*FW +: FW]), int'(hdr(6, 2, 5)));
        check("R8", int'(in_rdy[0]), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7", int'(out_bus[2*FW +: FW]), int'(hdr(6, 2, 5)));
        @(posedge clk); #1;
        out_rdy[2] = 1'b1;
        wait fork;
        drain("R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule